// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block decides which of three redundant reference clocks feeds a downstream phase-locked loop. It does not handle the clocks themselves. Per-input monitors elsewhere in the chip report a loss-of-signal alarm and a frequency-offset alarm for each reference. Both alarms arrive as synchronous inputs in this block's clock domain. The block turns them into a registered active-reference index, a flag telling whether that reference is usable, and a one-cycle pulse on every change of the index.

Two operating styles are offered. In manual operation a select input names the reference. In automatic operation the alarms drive the choice, and a fixed priority (input 0 first, then 1, then 2) breaks ties. Automatic operation can be revertive or non-revertive. Revertive operation moves back to a better reference once that reference has stayed clean for a programmable hold-off count. Non-revertive operation stays on any reference that is still clean. There is no data stream here, so every pin is plain level-sampled control or status.

Top module: `refsel_top`

## Requirements
- R1: While rst_n is low, active_idx is 0, active_valid is 0 and switch_pulse is 0.
- R2: An input is healthy only when both its los and fos bits are 0. Among candidates, the lowest index has the highest priority.
- R3: With auto_mode = 0, active_idx takes the value of manual_sel at the next rising edge when manual_sel is 0, 1 or 2. The value 3 leaves active_idx unchanged.
- R4: active_valid, registered together with active_idx, is 1 exactly when the input selected for the next cycle is healthy, in both manual and automatic operation.
- R5: With auto_mode = 1, if the active input is unhealthy and some input is healthy, the next edge selects the highest-priority healthy input.
- R6: With auto_mode = 1 and revertive = 1, while the active input is healthy the block moves to the highest-priority input of lower index that has been sampled healthy on at least holdoff+1 consecutive edges, counting the current one.
- R7: With auto_mode = 1 and revertive = 0, a healthy active input is kept, even when a higher-priority input is healthy.
- R8: With auto_mode = 1 and no input healthy, active_idx is held and active_valid becomes 0.
- R9: switch_pulse is 1 for exactly the cycle after each edge that changed active_idx, and 0 otherwise.
- R10: With holdoff = 0, a revert happens on the first edge at which the higher-priority input is sampled healthy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_mode | input | 1 | 1 = alarm-driven selection, 0 = manual selection |
| revertive | input | 1 | In automatic operation, 1 allows return to a better reference |
| manual_sel | input | 2 | Reference index used in manual operation |
| holdoff | input | HOLD_W (16) | Consecutive healthy samples required before a revert, minus one |
| los | input | 3 | Loss-of-signal alarm per reference, bit i for input i |
| fos | input | 3 | Frequency-offset alarm per reference, bit i for input i |
| active_idx | output | 2 | Index of the active reference |
| active_valid | output | 1 | Active reference is healthy |
| switch_pulse | output | 1 | One-cycle marker of an index change |

## Verification
Two decisions can meet in the same cycle. One is a failover caused by a new alarm on the active input. The other is a revert that has just become allowed because a higher-priority input's hold-off count matured. Failover must win: it lands on the best healthy input, not on whatever the revert logic proposes. The bench provokes this collision in a directed step, where the active input fails on the exact edge at which input 0 qualifies. Random stimulus with frequent alarm toggling produces many more such collisions. Every cycle, a bench reference model judges the index, the valid flag and the pulse.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;
  // Reason chosen for the next active index
  typedef enum logic [1:0] {
    DEC_KEEP     = 2'd0,
    DEC_MANUAL   = 2'd1,
    DEC_FAILOVER = 2'd2,
    DEC_REVERT   = 2'd3
  } refsel_dec_e;
endpackage

// File: rtl/refsel_health_mon.sv
`timescale 1ns/1ps
// Per-input health flag and consecutive-healthy counter with hold-off qualification
module refsel_health_mon #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              los,
  input  logic              fos,
  input  logic [HOLD_W-1:0] holdoff,
  output logic              healthy,
  output logic              qualified
);
  localparam logic [HOLD_W-1:0] CNT_MAX = '1;

  logic [HOLD_W-1:0] run_cnt;

  assign healthy   = !los && !fos;
  assign qualified = healthy && (run_cnt >= holdoff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!healthy) begin
      run_cnt <= '0;
    end else if (run_cnt != CNT_MAX) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/refsel_prio_pick.sv
`timescale 1ns/1ps
// Lowest set index wins
module refsel_prio_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/refsel_decide.sv
`timescale 1ns/1ps
// Combinational next-selection logic
module refsel_decide
  import refsel_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          auto_mode,
  input  logic          revertive,
  input  logic [IW-1:0] manual_sel,
  input  logic [IW-1:0] cur_idx,
  input  logic [N-1:0]  healthy,
  input  logic [N-1:0]  qualified,
  output logic [IW-1:0] next_idx
);
  localparam int PADN = 1 << IW;

  logic [PADN-1:0] h_pad;
  logic [N-1:0]    better_q;
  logic            any_h, any_q, cur_ok, man_ok;
  logic [IW-1:0]   best_h, best_q;
  refsel_dec_e     dec;

  always_comb begin
    h_pad        = '0;
    h_pad[N-1:0] = healthy;
  end

  // Only inputs ranked above the active one may be revert targets
  for (genvar g = 0; g < N; g++) begin : g_mask
    assign better_q[g] = qualified[g] && (IW'(g) < cur_idx);
  end

  refsel_prio_pick #(.N(N), .IW(IW)) u_pick_h (
    .req(healthy), .found(any_h), .idx(best_h)
  );
  refsel_prio_pick #(.N(N), .IW(IW)) u_pick_q (
    .req(better_q), .found(any_q), .idx(best_q)
  );

  assign cur_ok = h_pad[cur_idx];
  assign man_ok = int'(manual_sel) < N;

  always_comb begin
    if (!auto_mode) begin
      dec = man_ok ? DEC_MANUAL : DEC_KEEP;
    end else if (!cur_ok) begin
      dec = any_h ? DEC_FAILOVER : DEC_KEEP;
    end else if (revertive && any_q) begin
      dec = DEC_REVERT;
    end else begin
      dec = DEC_KEEP;
    end
  end

  always_comb begin
    unique case (dec)
      DEC_MANUAL:   next_idx = manual_sel;
      DEC_FAILOVER: next_idx = best_h;
      DEC_REVERT:   next_idx = best_q;
      default:      next_idx = cur_idx;
    endcase
  end
endmodule

// File: rtl/refsel_top.sv
`timescale 1ns/1ps
module refsel_top #(
  parameter int NUM_REFS = 3,
  parameter int HOLD_W   = 16,
  parameter int IW       = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_mode,
  input  logic              revertive,
  input  logic [IW-1:0]     manual_sel,
  input  logic [HOLD_W-1:0] holdoff,
  input  logic [NUM_REFS-1:0] los,
  input  logic [NUM_REFS-1:0] fos,
  output logic [IW-1:0]     active_idx,
  output logic              active_valid,
  output logic              switch_pulse
);
  localparam int PADN = 1 << IW;

  logic [NUM_REFS-1:0] healthy, qualified;
  logic [PADN-1:0]     h_pad;
  logic [IW-1:0]       next_idx;

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_mon
    refsel_health_mon #(.HOLD_W(HOLD_W)) u_mon (
      .clk(clk), .rst_n(rst_n), .los(los[g]), .fos(fos[g]),
      .holdoff(holdoff), .healthy(healthy[g]), .qualified(qualified[g])
    );
  end

  refsel_decide #(.N(NUM_REFS), .IW(IW)) u_decide (
    .auto_mode(auto_mode), .revertive(revertive), .manual_sel(manual_sel),
    .cur_idx(active_idx), .healthy(healthy), .qualified(qualified),
    .next_idx(next_idx)
  );

  always_comb begin
    h_pad               = '0;
    h_pad[NUM_REFS-1:0] = healthy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_idx   <= '0;
      active_valid <= 1'b0;
      switch_pulse <= 1'b0;
    end else begin
      active_idx   <= next_idx;
      active_valid <= h_pad[next_idx];
      switch_pulse <= (next_idx != active_idx);
    end
  end
endmodule

// File: rtl/refsel_checker.sv
`timescale 1ns/1ps
module refsel_checker #(
  parameter int NUM_REFS = 3,
  parameter int HOLD_W   = 16,
  parameter int IW       = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              auto_mode,
  input logic              revertive,
  input logic [IW-1:0]     manual_sel,
  input logic [HOLD_W-1:0] holdoff,
  input logic [NUM_REFS-1:0] los,
  input logic [NUM_REFS-1:0] fos,
  input logic [IW-1:0]     active_idx,
  input logic              active_valid,
  input logic              switch_pulse
);
  localparam int PADN = 1 << IW;

  logic [PADN-1:0] hp, hp_prev;
  logic            cur_ok, man_ok, none_ok;

  always_comb begin
    hp               = '0;
    hp[NUM_REFS-1:0] = ~los & ~fos;
  end
  assign cur_ok  = hp[active_idx];
  assign man_ok  = int'(manual_sel) < NUM_REFS;
  assign none_ok = (hp == '0);

  always_ff @(posedge clk) hp_prev <= hp;

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(active_idx) < NUM_REFS); // R3
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_idx != $past(active_idx)) |-> switch_pulse); // R9
  AST_PULSE_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (active_idx != $past(active_idx))); // R9
  AST_MANUAL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !auto_mode && man_ok) |-> (active_idx == $past(manual_sel))); // R3
  AST_NONE_HEALTHY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && auto_mode && none_ok) |-> ($stable(active_idx) && !active_valid)); // R8
  AST_NONREV_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && auto_mode && !revertive && cur_ok) |-> $stable(active_idx)); // R7
  AST_FAILOVER_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && auto_mode && !cur_ok && !none_ok) |-> (hp_prev[active_idx] && active_valid)); // R5
endmodule

bind refsel_top refsel_checker #(.NUM_REFS(NUM_REFS), .HOLD_W(HOLD_W), .IW(IW)) u_refsel_chk (
  .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .revertive(revertive),
  .manual_sel(manual_sel), .holdoff(holdoff), .los(los), .fos(fos),
  .active_idx(active_idx), .active_valid(active_valid), .switch_pulse(switch_pulse)
);

// File: tb/test_refsel_top.sv
`timescale 1ns/1ps
module test_refsel_top;
  localparam int N = 3;
  localparam int HW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_mode = 1'b1, revertive = 1'b1;
  logic [1:0] manual_sel = 2'd0;
  logic [HW-1:0] holdoff = 16'd3;
  logic [N-1:0] los = '0, fos = '0;
  logic [1:0] active_idx;
  logic active_valid, switch_pulse;

  int n_checks = 0, n_err = 0;
  bit done = 1'b0;

  // reference model state
  logic [1:0] m_idx;
  logic m_valid, m_pulse;
  int m_cnt [N];

  always #2.5 clk = ~clk;

  refsel_top i_refsel_top (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .revertive(revertive),
    .manual_sel(manual_sel), .holdoff(holdoff), .los(los), .fos(fos),
    .active_idx(active_idx), .active_valid(active_valid), .switch_pulse(switch_pulse)
  );

  function automatic logic is_ok(int i);
    return (i < N) && !los[i] && !fos[i];
  endfunction

  task automatic model_reset();
    m_idx = 0; m_valid = 0; m_pulse = 0;
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
  endtask

  // Advance the model by one edge using the inputs currently driven
  task automatic model_step();
    int nidx = m_idx;
    int best = -1;
    for (int i = N - 1; i >= 0; i--) if (is_ok(i)) best = i;
    if (!auto_mode) begin
      if (manual_sel < N) nidx = manual_sel;
    end else if (!is_ok(m_idx)) begin
      if (best >= 0) nidx = best;
    end else if (revertive) begin
      for (int i = int'(m_idx) - 1; i >= 0; i--)
        if (is_ok(i) && m_cnt[i] >= int'(holdoff)) nidx = i;
    end
    m_pulse = (nidx != int'(m_idx));
    m_valid = is_ok(nidx);
    m_idx = 2'(nidx);
    for (int i = 0; i < N; i++)
      m_cnt[i] = is_ok(i) ? ((m_cnt[i] < 65535) ? m_cnt[i] + 1 : m_cnt[i]) : 0;
  endtask

  task automatic check(string tag);
    n_checks++;
    if (active_idx !== m_idx || active_valid !== m_valid || switch_pulse !== m_pulse) begin
      n_err++;
      $display("FAIL %s: idx=%0d valid=%0b pulse=%0b expected idx=%0d valid=%0b pulse=%0b",
               tag, active_idx, active_valid, switch_pulse, m_idx, m_valid, m_pulse);
    end
  endtask

  // Inputs already driven at a falling edge; cross one rising edge, then check
  task automatic step(string tag);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: idx=%0d expected run to finish", active_idx);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    los = 3'b111; fos = 3'b000;
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst_n = 1'b1; los = '0;

    // all healthy, automatic revertive
    step("R2 all healthy");
    step("R9 no pulse");
    // R5 failover: los on 0
    los = 3'b001; step("R5 failover to 1");
    step("R9 pulse single");
    // R2 fos alone marks 1 unhealthy
    fos = 3'b010; step("R2 fos failover to 2");
    // R6 revert after hold-off (holdoff=3 -> 4th healthy sample)
    los = '0; fos = '0;
    step("R6 hold 1"); step("R6 hold 2"); step("R6 hold 3");
    step("R6 revert to 0");
    // collision: input 1 active, 0 qualifies on the edge that 1 fails
    los = 3'b001; step("R5 to 1");
    los = 3'b000; step("R6 hold a"); step("R6 hold b"); step("R6 hold c");
    los = 3'b010; step("R5 failover beats revert");
    // R7 non-revertive stays
    revertive = 0; los = 3'b001; step("R5 to 1 nonrev");
    los = '0;
    for (int k = 0; k < 8; k++) step("R7 stay on 1");
    // R8 none healthy
    los = 3'b111; step("R8 hold invalid"); step("R8 hold invalid 2");
    fos = 3'b010; los = 3'b000; step("R5 recover");
    // R10 zero hold-off
    revertive = 1; holdoff = 0; los = 3'b001; fos = 3'b000; step("R5 to 1 again");
    los = '0; step("R10 immediate revert");
    // R3 / R4 manual
    auto_mode = 0; manual_sel = 2; step("R3 manual 2");
    manual_sel = 3; step("R3 value 3 ignored");
    los = 3'b100; manual_sel = 2; step("R4 manual valid low");
    manual_sel = 0; step("R3 manual 0 despite priority");

    // constrained random
    holdoff = 3;
    for (int c = 0; c < 3000; c++) begin
      auto_mode  = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 15) == 0) revertive = ~revertive;
      manual_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 31) == 0) holdoff = 16'($urandom_range(0, 5));
      if ($urandom_range(0, 3) == 0) begin
        for (int i = 0; i < N; i++) begin
          los[i] = ($urandom_range(0, 5) == 0);
          fos[i] = ($urandom_range(0, 7) == 0);
        end
      end
      step(!auto_mode ? "R3 random manual" : (revertive ? "R6 random rev" : "R7 random nonrev"));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule